// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is a serial master for a four-channel, 12-bit successive-approximation converter. A one-cycle `start` pulse latches a request: channel, resolution, input type and power-down code. The block then drops chip select and sends an 8-bit control word, most significant bit first. It reads the conversion result back on `miso` and presents it on `result`, with a one-cycle `result_valid` strobe. The serial clock is divided down from the system clock. Output data changes on the falling serial edge, and input data is sampled on the rising edge.

The read can start at a fixed point in the frame, or it can wait until the converter's busy line has fallen. An overlapped mode starts the next control word in the last eight clocks of the current frame, so one conversion completes every 16 serial clocks. A conversion issued right after a channel change, or as the first one after reset, yields a result that is thrown away.

Top module: `adc_seq`

## Requirements
- R1: After reset `cs_n`=1, `sclk`=0, `mosi`=0, `result`=0, `result_valid`=0 and `busy_o`=0.
- R2: The control word is sent MSB first on `mosi`, one bit per serial clock, and the converter samples it on the rising edge.
  - Bit 7 is always 1.
  - Bits 6..4 hold the channel code: channel 0 = 001, 1 = 101, 2 = 010, 3 = 110.
  - Bit 3 is the resolution bit (1 = 8-bit).
  - Bit 2 is `sgl_dif`, and bits 1..0 are `pd`.
  - Example: channel 0, single-ended, 12-bit, pd=3 gives 8'h97.
- R3: When `res_strap`=0, bit 3 of the control word is sent as 0 and the result is a full 12-bit word, whatever `mode` is.
- R4: `sclk` is high only while `cs_n` is low, and its period is 2*DIV system clocks. A frame without overlap lasts 24 serial clocks: 8 command clocks and 16 read clocks.
- R5: With `wait_busy`=0, the 12 result bits are taken MSB first on rising serial edges 10 to 21 of the conversion. Edge 1 is the rising edge that carries the start bit.
- R6: With `wait_busy`=1, capture begins on the first rising edge at which `busy_in` is low after it was seen high following the command. Twelve consecutive bits are then taken with none skipped.
- R7: In 8-bit mode (bit 3 = 1), `result` holds the first eight received bits in [11:4] and zeros in [3:0].
- R8: A conversion whose channel differs from the previous conversion, or that is the first after reset, raises no `result_valid` and leaves `result` unchanged. Other conversions pulse `result_valid` for one cycle, and `result` changes only on that cycle.
- R9: With `overlap`=1 and a request pending at the falling edge of serial clock 16, the next control word starts on rising edge 17 without `cs_n` rising.
- R10: A `start` during a frame is held until the frame ends, and later requests overwrite the held fields. `busy_o` is high while a request is held or a frame runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; latches the fields below |
| channel | input | 2 | Channel number 0..3 |
| mode | input | 1 | 1 requests 8-bit resolution |
| sgl_dif | input | 1 | 1 single-ended, 0 differential |
| pd | input | 2 | Power-down code placed in bits 1..0 |
| overlap | input | 1 | Chain the next command into the current frame |
| wait_busy | input | 1 | Start capture on the busy falling edge |
| res_strap | input | 1 | 0 forces 12-bit resolution |
| miso | input | 1 | Serial data from the converter |
| busy_in | input | 1 | Converter busy flag |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the converter |
| result | output | 12 | Last valid conversion result |
| result_valid | output | 1 | One-cycle strobe for a new result |
| busy_o | output | 1 | Request held or frame in progress |

## Verification
The hardest situation to reach is an overlapped chain. The next request must already be held when serial clock 16 falls, and a third request must arrive while the second command is being shifted out. The bench models the converter at the pin level and records the serial clock on which each start bit appears. It waits for the second start bit to be seen before it issues the third request, and then checks that the three commands are 16 clocks apart in one 56-clock frame. A second hard case is the busy-wait read against a converter whose busy phase has been stretched by two clocks. A fixed-position read would then be misaligned, and only a correct busy-edge capture produces the expected word.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  channel,
  input  logic        mode,
  input  logic        sgl_dif,
  input  logic [1:0]  pd,
  input  logic        overlap,
  input  logic        wait_busy,
  input  logic        res_strap,
  input  logic        miso,
  input  logic        busy_in,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  output logic [11:0] result,
  output logic        result_valid,
  output logic        busy_o
);
  localparam int RES_W   = 12;
  localparam int CMD_W   = 8;
  localparam int FRAME_N = CMD_W + 16;
  localparam int OVL_N   = 16;
  localparam int FIX_IDX = CMD_W + 2;
  localparam int DW      = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int PW      = $clog2(FRAME_N + 1);
  localparam int BW      = $clog2(RES_W + 1);

  logic          pend, q_mode, q_sgl;
  logic [1:0]    q_ch, q_pd;
  logic          active, sclk_q, mosi_q;
  logic [DW-1:0] div_cnt;
  logic [PW-1:0] pos;
  logic [7:0]    cmd_sr;
  logic          cmd_m8, cmd_disc;
  logic          have_prev;
  logic [1:0]    prev_ch;
  logic          rd_on, rd_m8, rd_disc, busy_seen;
  logic [PW-1:0] rd_idx;
  logic [BW-1:0] rd_bits;
  logic [RES_W-2:0] rd_sr;

  logic tick, rise, fall, chain, launch, fin, cmd_done, rd_go, rd_last, new_disc;
  logic [PW-1:0]    rd_i;
  logic [7:0]       new_byte;
  logic [RES_W-1:0] rd_word;

  assign tick     = active && (div_cnt == DW'(DIV - 1));
  assign rise     = tick && !sclk_q;
  assign fall     = tick && sclk_q;
  assign chain    = fall && overlap && pend && (pos == PW'(OVL_N));
  assign launch   = (!active && pend) || chain;
  assign fin      = fall && (pos == PW'(FRAME_N));
  assign cmd_done = rise && (pos == PW'(CMD_W - 1));
  assign new_byte = {1'b1, q_ch[0], q_ch[1], ~q_ch[1], q_mode & res_strap, q_sgl, q_pd};
  assign new_disc = !have_prev || (q_ch != prev_ch);
  assign rd_i     = rd_idx + 1'b1;
  assign rd_word  = {rd_sr, miso};
  assign rd_go    = rd_on && rise && !cmd_done &&
                    ((rd_bits != '0) ||
                     (wait_busy ? (busy_seen && !busy_in) : (rd_i == PW'(FIX_IDX))));
  assign rd_last  = rd_go && (rd_bits == BW'(RES_W - 1));

  assign sclk   = sclk_q;
  assign cs_n   = ~active;
  assign mosi   = mosi_q;
  assign busy_o = active | pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; q_ch <= '0; q_pd <= '0; q_mode <= 1'b0; q_sgl <= 1'b0;
    end else if (start) begin
      pend <= 1'b1; q_ch <= channel; q_pd <= pd; q_mode <= mode; q_sgl <= sgl_dif;
    end else if (launch) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; sclk_q <= 1'b0; mosi_q <= 1'b0; div_cnt <= '0; pos <= '0;
      cmd_sr <= '0; cmd_m8 <= 1'b0; cmd_disc <= 1'b0; have_prev <= 1'b0; prev_ch <= '0;
    end else if (launch) begin
      active    <= 1'b1;
      sclk_q    <= 1'b0;
      div_cnt   <= '0;
      pos       <= '0;
      cmd_sr    <= new_byte;
      mosi_q    <= new_byte[7];
      cmd_m8    <= q_mode & res_strap;
      cmd_disc  <= new_disc;
      prev_ch   <= q_ch;
      have_prev <= 1'b1;
    end else if (active) begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) sclk_q <= ~sclk_q;
      if (rise) pos <= pos + 1'b1;
      if (fall) begin
        if (pos < PW'(CMD_W)) begin
          cmd_sr <= {cmd_sr[6:0], 1'b0};
          mosi_q <= cmd_sr[6];
        end else begin
          mosi_q <= 1'b0;
        end
        if (fin) active <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_on <= 1'b0; rd_m8 <= 1'b0; rd_disc <= 1'b0; busy_seen <= 1'b0;
      rd_idx <= '0; rd_bits <= '0; rd_sr <= '0; result <= '0; result_valid <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (cmd_done) begin
        rd_on     <= 1'b1;
        rd_idx    <= PW'(CMD_W);
        rd_bits   <= '0;
        busy_seen <= 1'b0;
        rd_m8     <= cmd_m8;
        rd_disc   <= cmd_disc;
      end else if (rise && rd_on) begin
        rd_idx <= rd_i;
        if (busy_in) busy_seen <= 1'b1;
        if (rd_go) begin
          rd_sr   <= rd_word[RES_W-2:0];
          rd_bits <= rd_bits + 1'b1;
        end
        if (rd_last) begin
          rd_on <= 1'b0;
          if (!rd_disc) begin
            result       <= rd_m8 ? {rd_word[RES_W-1:4], 4'h0} : rd_word;
            result_valid <= 1'b1;
          end
        end
      end else if (fin) begin
        rd_on <= 1'b0;
      end
    end
  end

  a_r2_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> mosi);
  a_r2_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));
  a_r3_strap_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !res_strap) |=> !cmd_sr[3]);
  a_r4_clk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result));
endmodule

// File: tb/adc_seq_tb.sv
`timescale 1ns/1ps
module adc_seq_tb;
  localparam int DIV = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, sgl_dif = 1'b0, overlap = 1'b0, wait_busy = 1'b0, res_strap = 1'b1;
  logic [1:0] channel = '0, pd = '0;
  logic miso = 1'b0, busy_in = 1'b0;
  logic sclk, cs_n, mosi, result_valid, busy_o;
  logic [11:0] result;

  always #2 clk = ~clk;

  adc_seq #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .channel(channel), .mode(mode),
    .sgl_dif(sgl_dif), .pd(pd), .overlap(overlap), .wait_busy(wait_busy),
    .res_strap(res_strap), .miso(miso), .busy_in(busy_in), .sclk(sclk),
    .cs_n(cs_n), .mosi(mosi), .result(result), .result_valid(result_valid),
    .busy_o(busy_o));

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R5";

  function automatic void chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  logic [11:0] chan_val [4];
  int bdly = 0;
  int gclk = 0, rx_cnt = 0, out_start = 1000, busy_from = 1000, prev_chn = -1;
  logic [7:0]  rx_byte = '0, last_rx = '0;
  logic [11:0] out_word = '0, last_res = '0;
  logic [7:0]  exp_cmd[$];
  logic [11:0] exp_res[$];
  int start_g[$];
  int rises_in_frame = 0, exp_len = 24, last_rise = 0;

  function automatic logic [2:0] ch2code(input int ch);
    case (ch)
      0: return 3'b001;
      1: return 3'b101;
      2: return 3'b010;
      default: return 3'b110;
    endcase
  endfunction

  function automatic int code2ch(input logic [2:0] c);
    case (c)
      3'b001: return 0;
      3'b101: return 1;
      3'b010: return 2;
      3'b110: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic void took_cmd(input int g);
    logic [7:0] e;
    logic [11:0] w;
    int chn;
    last_rx = rx_byte;
    if (exp_cmd.size() == 0) chk(1'b0, "R2 unexpected control word", int'(rx_byte), 0);
    else begin
      e = exp_cmd.pop_front();
      chk(rx_byte == e, "R2 control word (R3 strap bit)", int'(rx_byte), int'(e));
    end
    chn = code2ch(rx_byte[6:4]);
    if (chn < 0) begin
      chk(1'b0, "R2 channel code", int'(rx_byte[6:4]), 0);
      chn = 0;
    end
    w = chan_val[chn];
    if (rx_byte[3]) w = {w[11:4], 4'h0};
    out_word  = w;
    busy_from = g;
    out_start = g + 1 + bdly;
    if (prev_chn == chn) exp_res.push_back(w);
    prev_chn = chn;
  endfunction

  // converter model
  always @(posedge sclk or negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      gclk = 0; rx_cnt = 0; out_start = 1000; busy_from = 1000;
      miso = 1'b0; busy_in = 1'b0;
    end else if (sclk) begin
      gclk++;
      if (rx_cnt == 0) begin
        if (mosi) begin
          rx_cnt = 1; rx_byte = 8'h01; start_g.push_back(gclk);
        end
      end else begin
        rx_byte = {rx_byte[6:0], mosi};
        rx_cnt++;
        if (rx_cnt == 8) begin
          rx_cnt = 0;
          took_cmd(gclk);
        end
      end
    end else begin
      busy_in = (gclk >= busy_from) && (gclk < out_start);
      miso = (gclk >= out_start && gclk < out_start + 12) ? out_word[11 - (gclk - out_start)] : 1'b0;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge sclk) begin
    if (rises_in_frame > 0) chk(cyc - last_rise == 2 * DIV, "R4 sclk period", cyc - last_rise, 2 * DIV);
    last_rise = cyc;
    rises_in_frame++;
  end

  always @(posedge cs_n) begin
    if (rst_n) begin
      chk(rises_in_frame == exp_len, "R4 frame length", rises_in_frame, exp_len);
      rises_in_frame = 0;
    end
  end

  // per-clock comparison against the reference queues
  always @(negedge clk) begin
    logic [11:0] w;
    if (rst_n) begin
      if (sclk) chk(!cs_n, "R4 sclk outside frame", int'(cs_n), 0);
      if (result_valid) begin
        if (exp_res.size() == 0) chk(1'b0, "R8 valid on discarded conversion", int'(result), 0);
        else begin
          w = exp_res.pop_front();
          chk(result == w, {cur_req, " result word"}, int'(result), int'(w));
        end
        last_res = result;
      end else begin
        chk(result == last_res, "R8 result held", int'(result), int'(last_res));
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      chk(1'b0, "watchdog expired", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_start(input int ch, input bit m, input bit s, input logic [1:0] p, input bit push);
    @(negedge clk);
    channel = ch[1:0]; mode = m; sgl_dif = s; pd = p; start = 1'b1;
    if (push) exp_cmd.push_back({1'b1, ch2code(ch), m & res_strap, s, p});
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle;
    do @(negedge clk); while (busy_o);
    repeat (3) @(negedge clk);
  endtask

  task automatic end_test(input string req);
    chk(exp_cmd.size() == 0, {req, " commands delivered"}, exp_cmd.size(), 0);
    chk(exp_res.size() == 0, {req, " valid results delivered"}, exp_res.size(), 0);
  endtask

  initial begin
    chan_val[0] = 12'h8A5; chan_val[1] = 12'h3C1; chan_val[2] = 12'hF0E; chan_val[3] = 12'h5A6;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
    chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
    chk(mosi == 1'b0, "R1 mosi", int'(mosi), 0);
    chk(result_valid == 1'b0, "R1 result_valid", int'(result_valid), 0);
    chk(result == 12'h0, "R1 result", int'(result), 0);
    chk(busy_o == 1'b0, "R1 busy_o", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R5 R8: channel 0, first discarded then valid
    cur_req = "R5";
    do_start(0, 1'b0, 1'b1, 2'd3, 1'b1);
    chk(busy_o == 1'b1, "R10 busy_o after start", int'(busy_o), 1);
    wait_idle();
    chk(last_rx == 8'h97, "R2 channel 0 word", int'(last_rx), 8'h97);
    do_start(0, 1'b0, 1'b1, 2'd3, 1'b1);
    wait_idle();
    end_test("R8");

    // R2 R8: differential channel 1, pd 0
    do_start(1, 1'b0, 1'b0, 2'd0, 1'b1);
    wait_idle();
    chan_val[1] = 12'hA5C;
    do_start(1, 1'b0, 1'b0, 2'd0, 1'b1);
    wait_idle();
    end_test("R2");

    // R7: 8-bit result
    cur_req = "R7";
    do_start(1, 1'b1, 1'b1, 2'd2, 1'b1);
    wait_idle();
    end_test("R7");

    // R3: strap low forces 12-bit
    cur_req = "R3";
    res_strap = 1'b0;
    do_start(1, 1'b1, 1'b0, 2'd1, 1'b1);
    wait_idle();
    res_strap = 1'b1;
    end_test("R3");

    // R6: busy-edge capture with stretched busy
    cur_req = "R6";
    wait_busy = 1'b1; bdly = 2; chan_val[1] = 12'h6D3;
    do_start(1, 1'b0, 1'b1, 2'd3, 1'b1);
    wait_idle();
    wait_busy = 1'b0; bdly = 0;
    end_test("R6");

    // R9: overlapped chain of three
    cur_req = "R9";
    overlap = 1'b1; exp_len = 56; start_g.delete();
    do_start(2, 1'b0, 1'b1, 2'd3, 1'b1);
    do_start(2, 1'b0, 1'b1, 2'd3, 1'b1);
    while (start_g.size() < 2) @(negedge clk);
    chan_val[2] = 12'h1E7;
    do_start(2, 1'b0, 1'b1, 2'd3, 1'b1);
    wait_idle();
    chk(start_g.size() == 3, "R9 three commands in one frame", start_g.size(), 3);
    if (start_g.size() == 3) begin
      chk(start_g[1] - start_g[0] == 16, "R9 second command spacing", start_g[1] - start_g[0], 16);
      chk(start_g[2] - start_g[1] == 16, "R9 third command spacing", start_g[2] - start_g[1], 16);
    end
    overlap = 1'b0; exp_len = 24;
    end_test("R9");

    // R10: requests during a frame are held, latest wins
    cur_req = "R10";
    start_g.delete();
    do_start(3, 1'b0, 1'b1, 2'd3, 1'b1);
    repeat (20) @(negedge clk);
    do_start(0, 1'b0, 1'b1, 2'd3, 1'b0);
    do_start(2, 1'b0, 1'b1, 2'd3, 1'b1);
    wait_idle();
    chk(start_g.size() == 2, "R10 two frames issued", start_g.size(), 2);
    do_start(2, 1'b0, 1'b1, 2'd3, 1'b1);
    wait_idle();
    chk(busy_o == 1'b0, "R10 busy_o idle", int'(busy_o), 0);
    end_test("R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule